// File: doc/BRIEF.md
# Reset Cause Classifier with Debounce

This block works out why the system left reset and reports the cause as a one-hot code. Boot logic uses that code to pick its start-up path. After reset is released, the block counts a fixed number of millisecond ticks so that external wake lines can settle. It then takes one sample of a three-bit wake-status vector, which first passes through a flop synchronizer. The sample is classified with a fixed priority that does not follow bit-index order.

The result comes out with a one-cycle valid strobe. In the same cycle the block sends a one-cycle pulse that tells the wake logic to clear its mask, so that later stray events are not reported. The cause is then held unchanged until the next reset. The delay length and the synchronizer depth are parameters.

Top module: `reset_cause_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `cause` is 4'b0000 and `cause_valid` and `mask_clr` are low until classification happens.
- R2: `cause_valid` stays low until `DEBOUNCE_MS` (default 10) `ms_tick` pulses have been seen after reset release. It rises one clock after the edge that captures the last of those ticks.
- R3: If wake bit 2 (hibernate) is set in the sample, `cause` is 4'b0001 (bit 0), whatever the other bits are.
- R4: If bit 2 is clear and wake bit 0 (hardware reset) is set, `cause` is 4'b0010 (bit 1), whatever bit 1 is.
- R5: If only wake bit 1 (sleep wakeup) is set, `cause` is 4'b0100 (bit 2).
- R6: If no wake bit is set, `cause` is 4'b1000 (bit 3, run-time reset).
- R7: `cause_valid` and `mask_clr` are each high for exactly one cycle, both in the same cycle.
- R8: Once reported, `cause` holds its value until the next reset. Later wake changes and ticks have no effect and produce no further strobe.
- R9: The wake vector passes through a `SYNC_STAGES`-flop synchronizer (default 2). A change applied in the same cycle as the final tick is not seen, and the value from before the change is classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| wake_src | input | 3 | Wake-status vector: bit 2 hibernate, bit 0 hardware, bit 1 sleep |
| cause | output | 4 | One-hot cause: bit 0 hibernate, bit 1 hardware, bit 2 sleep, bit 3 run-time |
| cause_valid | output | 1 | One-cycle strobe when the cause is first reported |
| mask_clr | output | 1 | One-cycle pulse that clears the wake mask |

## Verification
An error in the tick counter shows up at the ports as a strobe that comes one or more ticks early or late, or never comes. An error in the state register shows up as a second strobe, or as a cause that changes after it was reported. Both are caught within a few cycles of the expected sample point. A fault in the priority network gives a wrong or multi-hot code at the strobe. A sync chain that is too short shows up when a change is made at the final tick. Every wake pattern is swept, each with its own reset, so every priority branch is covered.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
   localparam int WAKE_W  = 3;
   localparam int CAUSE_W = 4;

   localparam int WK_HIB  = 2;
   localparam int WK_HARD = 0;
   localparam int WK_SLP  = 1;

   localparam logic [CAUSE_W-1:0] C_HIB  = 4'b0001;
   localparam logic [CAUSE_W-1:0] C_HARD = 4'b0010;
   localparam logic [CAUSE_W-1:0] C_SLP  = 4'b0100;
   localparam logic [CAUSE_W-1:0] C_RUN  = 4'b1000;

   typedef enum logic [0:0] {ST_WAIT = 1'b0, ST_DONE = 1'b1} rcc_state_e;
endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rcc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcc_timer.sv
module rcc_timer #(
   parameter int LIMIT = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic expired
);
   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad
         $error("rcc_timer: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         expired <= 1'b0;
      end else if (!expired && tick) begin
         if (cnt == LAST) expired <= 1'b1;
         else             cnt     <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/rcc_encoder.sv
module rcc_encoder
   import rcc_pkg::*;
(
   input  logic [WAKE_W-1:0]  wake,
   output logic [CAUSE_W-1:0] code
);
   always_comb begin
      if (wake[WK_HIB])       code = C_HIB;
      else if (wake[WK_HARD]) code = C_HARD;
      else if (wake[WK_SLP])  code = C_SLP;
      else                    code = C_RUN;
   end
endmodule

// File: rtl/reset_cause_classifier.sv
module reset_cause_classifier
   import rcc_pkg::*;
#(
   parameter int DEBOUNCE_MS = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ms_tick,
   input  logic [WAKE_W-1:0]   wake_src,
   output logic [CAUSE_W-1:0]  cause,
   output logic                cause_valid,
   output logic                mask_clr
);
   logic [WAKE_W-1:0]  wake_sync;
   logic [CAUSE_W-1:0] code;
   logic               expired;
   rcc_state_e         state;

   rcc_sync #(.W(WAKE_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(wake_src), .q(wake_sync)
   );

   rcc_timer #(.LIMIT(DEBOUNCE_MS)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick), .expired(expired)
   );

   rcc_encoder u_enc (.wake(wake_sync), .code(code));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_WAIT;
         cause       <= '0;
         cause_valid <= 1'b0;
         mask_clr    <= 1'b0;
      end else begin
         cause_valid <= 1'b0;
         mask_clr    <= 1'b0;
         if (state == ST_WAIT && expired) begin
            state       <= ST_DONE;
            cause       <= code;
            cause_valid <= 1'b1;
            mask_clr    <= 1'b1;
         end
      end
   end
endmodule

module reset_cause_classifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] cause,
   input logic       cause_valid,
   input logic       mask_clr,
   input logic       expired,
   input logic [2:0] wake_sync
);
   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |=> !cause_valid);
   a_r7_mask_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr |=> !mask_clr);
   a_r7_mask_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |-> mask_clr);
   a_r2_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |-> $past(expired));
   a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |-> ($countones(cause) == 1));
   a_r3_hibernate_first: assert property (@(posedge clk) disable iff (!rst_n)
      cause_valid |-> (cause[0] == $past(wake_sync[2])));
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cause != 4'b0000) |=> $stable(cause));
   a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !expired |=> (cause == 4'b0000));
endmodule

bind reset_cause_classifier reset_cause_classifier_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cause(cause), .cause_valid(cause_valid),
   .mask_clr(mask_clr), .expired(expired), .wake_sync(wake_sync)
);

// File: tb/test_reset_cause_classifier.sv
module test_reset_cause_classifier;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0;
   logic [2:0] wake_src = 3'b000;
   logic [3:0] cause;
   logic       cause_valid;
   logic       mask_clr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam int N = 10;

   always #5 clk = ~clk;

   reset_cause_classifier i_reset_cause_classifier (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wake_src(wake_src),
      .cause(cause), .cause_valid(cause_valid), .mask_clr(mask_clr)
   );

   function automatic logic [3:0] expect_cause(input logic [2:0] w);
      if (w[2])      return 4'b0001;
      else if (w[0]) return 4'b0010;
      else if (w[1]) return 4'b0100;
      else           return 4'b1000;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
   endtask

   task automatic run_case(input logic [2:0] w, input bit late, input logic [2:0] w2);
      rst_n = 1'b0;
      wake_src = w;
      repeat (3) @(negedge clk);
      chk(cause == 4'b0 && !cause_valid && !mask_clr, "R1", {cause, cause_valid, mask_clr}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < N-1; i++) begin
         tick();
         @(negedge clk);
         chk(!cause_valid && cause == 4'b0, "R2", {cause, cause_valid}, 0);
      end
      @(negedge clk) begin
         ms_tick = 1'b1;
         if (late) wake_src = w2;
      end
      @(negedge clk) ms_tick = 1'b0;
      chk(!cause_valid, "R2", cause_valid, 0);
      @(negedge clk);
      chk(cause_valid == 1'b1, "R2", cause_valid, 1);
      chk(mask_clr == 1'b1, "R7", mask_clr, 1);
      if (late)
         chk(cause == expect_cause(w), "R9", cause, expect_cause(w));
      else if (w[2])
         chk(cause == expect_cause(w), "R3", cause, expect_cause(w));
      else if (w[0])
         chk(cause == expect_cause(w), "R4", cause, expect_cause(w));
      else if (w[1])
         chk(cause == expect_cause(w), "R5", cause, expect_cause(w));
      else
         chk(cause == expect_cause(w), "R6", cause, expect_cause(w));
      @(negedge clk);
      chk(!cause_valid && !mask_clr, "R7", {cause_valid, mask_clr}, 0);
      wake_src = ~w;
      for (int i = 0; i < 3; i++) tick();
      repeat (4) @(negedge clk);
      chk(cause == expect_cause(w) && !cause_valid, "R8",
          {cause, cause_valid}, {expect_cause(w), 1'b0});
   endtask

   initial begin
      for (int v = 0; v < 8; v++) run_case(3'(v), 1'b0, 3'b000);
      run_case(3'b000, 1'b1, 3'b100);
      run_case(3'b010, 1'b1, 3'b001);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule